// File: doc/BRIEF.md
# PS/2 Receive Port with Register Interface

This block attaches a PS/2 keyboard or mouse to a processor bus. A small deserializer watches the device's clock and data lines. It takes each 11-bit frame on the falling edges of the synchronized device clock and checks the frame. Good bytes go into a deep receive queue. The processor sees the port as two 32-bit registers. The data word is at offset 0 and the control word is at offset 4.

Reading the data word returns the oldest queued byte, a valid flag and the current queue occupancy, and the read removes that byte from the queue. The occupancy includes the byte returned by that read, so software can drain the queue by repeating the read until the valid flag is clear. The read has a side effect, so software must keep the value of one read instead of reading the register twice.

When the receive enable is on, an interrupt line stays high for as long as the queue holds anything. Software clears it only by draining the queue. Writing the data word passes a command byte to a transmit path. That path is a simple request/acknowledge stub, and an error returned with the acknowledge sets a sticky error flag in the control word.

Top module: `ps2_rx_port`

## Requirements
- R1: After reset both registers read 0, `irq` is low and `cmd_valid` is low.
- R2: A frame of start bit 0, eight data bits LSB first, an odd parity bit and stop bit 1 is sampled on falling edges of the synchronized `ps2_clk`, and its data byte is appended to the queue.
- R3: A frame whose parity is even or whose stop bit is 0 is dropped and the queue is unchanged. A falling edge that sees 1 on the data line while idle does not start a frame.
- R4: A read at offset 0 (`bus_addr[2]`=0) returns the head byte in bits 7:0, 1 in bit 15 when the queue is non-empty, and the occupancy (including the returned byte) in bits 31:16. All other bits are 0. When the queue is empty the whole word is 0.
- R5: A data read while the queue is non-empty removes the head byte, so bytes come out in arrival order. A data read while the queue is empty changes nothing.
- R6: The queue holds DEPTH (256) bytes. A byte that completes while the queue is full is discarded, and the bytes already queued stay intact.
- R7: The control word at offset 4 (`bus_addr[2]`=1) holds the receive enable in bit 0, which is read/write, the pending flag in bit 8, which is read-only, and the command error flag in bit 10. All other bits read 0.
- R8: `irq` and control bit 8 are 1 exactly when the receive enable is 1 and the queue is non-empty. Once set, they clear only when the queue is emptied or the enable is written 0.
- R9: A data-word write while no command is pending raises `cmd_valid` with bits 7:0 on `cmd_byte`. These are held until the cycle in which `cmd_ack` is high, and a data write while a command is pending is ignored.
- R10: `cmd_ack` with `cmd_err` high sets control bit 10. The flag stays set until a control write with bit 10 at 0, and a control write with bit 10 at 1 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ps2_clk | input | 1 | Device clock line, asynchronous |
| ps2_dat | input | 1 | Device data line, asynchronous |
| bus_addr | input | 3 | Byte address; bit 2 selects the control word |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid during the read cycle |
| irq | output | 1 | Interrupt request, level |
| cmd_valid | output | 1 | Command byte waiting for the transmit path |
| cmd_byte | output | 8 | Command byte |
| cmd_ack | input | 1 | Transmit path accepted the command |
| cmd_err | input | 1 | Qualifies `cmd_ack`: the send failed |

## Verification
The assertions assume three things about the inputs. Each bus read or write strobe lasts one cycle. `cmd_ack` arrives only while a command is pending. The device clock half-periods are much longer than the synchronizer, so each falling edge is seen once. The bench keeps to these rules. It drives every strobe as a single-cycle pulse placed between clock edges, and it holds each half of the PS/2 clock for several system cycles. It acknowledges only commands it has just seen on `cmd_valid`. The bench sends all 256 byte values in order, which fills the queue exactly. It then sends one extra byte to test the full condition and drains the queue, checking each byte and each occupancy value arithmetically.

// File: rtl/ps2_rx_port.sv
module ps2_rx_port #(
  parameter int DEPTH = 256,
  parameter int SYNC  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ps2_clk,
  input  logic        ps2_dat,
  input  logic [2:0]  bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  output logic        cmd_valid,
  output logic [7:0]  cmd_byte,
  input  logic        cmd_ack,
  input  logic        cmd_err
);

  localparam int AW = $clog2(DEPTH);

  logic [SYNC-1:0] kclk_s, kdat_s;
  logic            kclk_d;
  logic [3:0]      bitcnt;
  logic [8:0]      shreg;
  logic [7:0]      mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [AW:0]     cnt;
  logic            re, ce;

  wire fall      = kclk_d & ~kclk_s[SYNC-1];
  wire din       = kdat_s[SYNC-1];
  wire frame_ok  = fall && bitcnt == 4'd10 && din && ^shreg;
  wire full      = cnt == (AW+1)'(DEPTH);
  wire nonempty  = cnt != '0;
  wire push      = frame_ok && !full;
  wire sel_ctrl  = bus_addr[2];
  wire pop       = bus_rd && !sel_ctrl && nonempty;
  wire ctrl_wr   = bus_wr && sel_ctrl;
  wire [7:0] head = mem[rp];
  wire unused_bits = ^{bus_addr[1:0], bus_wdata[31:11], bus_wdata[9:8]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kclk_s <= '1;
      kdat_s <= '1;
      kclk_d <= 1'b1;
    end else begin
      kclk_s <= {kclk_s[SYNC-2:0], ps2_clk};
      kdat_s <= {kdat_s[SYNC-2:0], ps2_dat};
      kclk_d <= kclk_s[SYNC-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitcnt <= '0;
      shreg  <= '0;
    end else if (fall) begin
      if (bitcnt == 4'd0) begin
        if (!din) bitcnt <= 4'd1;
      end else begin
        if (bitcnt != 4'd10) shreg <= {din, shreg[8:1]};
        bitcnt <= (bitcnt == 4'd10) ? 4'd0 : bitcnt + 4'd1;
      end
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= shreg[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re        <= 1'b0;
      ce        <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
    end else begin
      if (ctrl_wr) re <= bus_wdata[0];
      if (cmd_valid && cmd_ack && cmd_err) ce <= 1'b1;
      else if (ctrl_wr && !bus_wdata[10]) ce <= 1'b0;
      if (bus_wr && !sel_ctrl && !cmd_valid) begin
        cmd_valid <= 1'b1;
        cmd_byte  <= bus_wdata[7:0];
      end else if (cmd_valid && cmd_ack) begin
        cmd_valid <= 1'b0;
      end
    end
  end

  assign irq = re && nonempty;

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[0]  = re;
      bus_rdata[8]  = irq;
      bus_rdata[10] = ce;
    end else if (nonempty) begin
      bus_rdata[31:16] = 16'(cnt);
      bus_rdata[15]    = 1'b1;
      bus_rdata[7:0]   = head;
    end
  end

  // R6
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && full && !bus_rd) |=> cnt == $past(cnt) && wp == $past(wp));

  // R5
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !frame_ok) |=> cnt == $past(cnt) - 1'b1);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> (irq || cnt == '0));

  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ack) |=> (cmd_valid && $stable(cmd_byte)));

  // R10
  ce_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !(ctrl_wr && !bus_wdata[10])) |=> ce);

endmodule

// File: tb/test_ps2_rx_port.sv
module test_ps2_rx_port;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 4;
  localparam int DEPTH = 256;

  logic clk = 0, rst_n = 0, ps2_clk = 1, ps2_dat = 1;
  logic [2:0] bus_addr = 0;
  logic bus_rd = 0, bus_wr = 0, cmd_ack = 0, cmd_err = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, cmd_valid;
  logic [7:0] cmd_byte;
  int nchk = 0, nerr = 0;
  logic [31:0] v;

  ps2_rx_port #(.DEPTH(DEPTH)) i_ps2_rx_port (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  task automatic ps2_bit(input logic b);
    ps2_dat = b;
    repeat (HP) @(negedge clk);
    ps2_clk = 0;
    repeat (HP) @(negedge clk);
    ps2_clk = 1;
  endtask

  task automatic send(input logic [7:0] b, input logic bad_par = 0, input logic bad_stop = 0);
    ps2_bit(1'b0);
    for (int i = 0; i < 8; i++) ps2_bit(b[i]);
    ps2_bit(~^b ^ bad_par);
    ps2_bit(~bad_stop);
    ps2_dat = 1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic rd(input logic ctrl, output logic [31:0] d);
    @(negedge clk);
    bus_addr = ctrl ? 3'd4 : 3'd0;
    bus_rd = 1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wr(input logic ctrl, input logic [31:0] d);
    @(negedge clk);
    bus_addr = ctrl ? 3'd4 : 3'd0;
    bus_wdata = d;
    bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic ack(input logic e);
    @(negedge clk);
    cmd_ack = 1;
    cmd_err = e;
    @(negedge clk);
    cmd_ack = 0;
    cmd_err = 0;
  endtask

  function automatic logic [31:0] dword(input logic [7:0] b, input int n);
    return (n == 0) ? 32'h0 : {16'(n), 1'b1, 7'b0, b};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(0, v); check("R1 data", v, 0);
    rd(1, v); check("R1 ctrl", v, 0);
    check("R1 irq", irq, 0);
    check("R1 cmd_valid", cmd_valid, 0);

    // R2, R4 single byte
    send(8'h1C);
    rd(1, v); check("R8 no irq while RE=0", v, 0);
    check("R8 irq low", irq, 0);
    wr(1, 32'h1);
    check("R8 irq high", irq, 1);
    rd(1, v); check("R7 ctrl RE+RI", v, 32'h101);
    rd(0, v); check("R2 R4 first byte", v, dword(8'h1C, 1));
    check("R8 irq cleared by drain", irq, 0);
    rd(0, v); check("R5 empty read", v, 0);
    rd(1, v); check("R7 ctrl RE only", v, 32'h1);

    // R3 bad frames
    send(8'h55, 1, 0);
    send(8'hAA, 0, 1);
    rd(0, v); check("R3 bad frames dropped", v, 0);
    check("R3 irq low", irq, 0);

    // R5 ordering
    send(8'h00); send(8'hFF); send(8'h81);
    rd(0, v); check("R5 order 0", v, dword(8'h00, 3));
    rd(0, v); check("R5 order 1", v, dword(8'hFF, 2));
    rd(0, v); check("R5 order 2", v, dword(8'h81, 1));
    rd(0, v); check("R5 drained", v, 0);

    // R6 full sweep of all byte values, then overflow
    for (int i = 0; i < DEPTH; i++) send(8'(i));
    send(8'hA5);
    rd(1, v); check("R8 RI full", v, 32'h101);
    for (int i = 0; i < DEPTH; i++) begin
      check("R8 irq while data", irq, 1);
      rd(0, v); check("R6 sweep byte", v, dword(8'(i), DEPTH - i));
    end
    rd(0, v); check("R6 overflow byte discarded", v, 0);
    check("R8 irq after sweep", irq, 0);
    send(8'h3C);
    wr(1, 32'h0);
    check("R8 irq off by RE=0", irq, 0);
    rd(0, v); check("R4 data with RE=0", v, dword(8'h3C, 1));

    // R9 command path
    wr(0, 32'h1234_56C3);
    check("R9 cmd_valid", cmd_valid, 1);
    check("R9 cmd_byte", cmd_byte, 8'hC3);
    wr(0, 32'h11);
    check("R9 write while pending ignored", cmd_byte, 8'hC3);
    ack(0);
    check("R9 cmd_valid cleared", cmd_valid, 0);
    rd(1, v); check("R10 no error", v, 0);

    // R10 error flag
    wr(0, 32'h5A);
    check("R9 second cmd", cmd_byte, 8'h5A);
    ack(1);
    rd(1, v); check("R10 CE set", v, 32'h400);
    wr(1, 32'h401);
    rd(1, v); check("R10 CE kept, R7 RE set", v, 32'h401);
    wr(1, 32'hFFFF_FFFE);
    rd(1, v); check("R7 reserved zero", v, 32'h400);
    wr(1, 32'h0);
    rd(1, v); check("R10 CE cleared", v, 0);

    summary();
  end
endmodule